// File: doc/BRIEF.md
# First-Order Three-Level Delta-Sigma Modulator

This block turns a stream of signed fixed-point samples into a coarse three-level code whose running average follows the input. Each accepted sample is added to an accumulator. The level chosen on the previous step, scaled to full scale, is subtracted in the same step. Because of this feedback, the quantization error appears at the output only as its first difference: y(n) = x(n-1) + e(n) - e(n-1). The error is pushed toward high frequencies, and a downstream decimator running at about 32 output samples per Nyquist-rate sample can remove it.

The accumulator works as a delaying integrator. The quantizer reads the stored state before the new sample is added in. A programmable leak multiplies the state by (1 - 2^-k) on each accepted sample, which models an integrator with finite gain and moves the noise-transfer zero inward. Setting the shift to zero turns the leak off. The accumulator has guard bits above the input width. If the sum falls outside that range, the accumulator clamps instead of wrapping, and a sticky flag records that it happened.

The block also reports the error term of the step that produced the current level. Full scale FS is 2^(DW-1).

Top module: `dsm1_modulator`

## Requirements
- R1: A synchronous reset drives `level`, `qerr`, `sat_seen` and the accumulator to zero. After reset the first accepted sample gives level 0.
- R2: `level` is a two-bit signed code: 2'b01 means +1, 2'b00 means 0 and 2'b11 means -1. The value 2'b10 never appears.
- R3: The quantizer gives +1 when the state is strictly above FS/2 and -1 when it is strictly below -FS/2. A state of exactly +FS/2 or -FS/2 gives 0.
- R4: On each accepted sample, `level` takes Q(s) from the pre-update state s. The state becomes leak(s) + x - Q(s)*FS. Both registers update at the clock edge that samples `in_valid`.
- R5: While `in_valid` is low, `level`, `qerr` and the accumulator hold their values, whatever `in_sample` does.
- R6: If `leak_shift` = k is nonzero, leak(s) = s - (s >>> k), using an arithmetic shift. If k = 0, leak(s) = s.
- R7: If leak(s) + x - Q(s)*FS falls outside the IW-bit signed range, the state clamps to the nearest limit and `sat_seen` goes high. `sat_seen` then stays high until reset.
- R8: `qerr` equals Q(s)*FS - s for the same step that produced `level`. While `level` is 0, `|qerr|` is at most FS/2.
- R9: With no leak and a constant input after reset, the sum of 32 consecutive levels times FS is within 2*FS of 32 times the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | DW | Signed input sample |
| leak_shift | input | KW | Leak shift k; 0 turns the leak off |
| level | output | 2 | Signed output level code |
| qerr | output | IW | Quantization error of the last step |
| sat_seen | output | 1 | Sticky accumulator saturation flag |

## Verification
Four properties are checked on every cycle: the level code is always legal, the outputs hold between strobes, the saturation flag is sticky, and the error stays bounded whenever the level is zero. The bench scenarios cover what depends on the arithmetic itself. These are the exact recursion, checked against a bit-accurate model under random inputs with and without leak, and the threshold ties at exactly ±FS/2. They also cover clamping, which can only be reached by an instance with no guard bits, and the tracking of a constant input by the 32-sample average.

// File: rtl/dsm1_modulator.sv
module dsm1_modulator #(
  parameter int DW = 12,
  parameter int GW = 4,
  parameter int KW = 4,
  localparam int IW = DW + GW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_sample,
  input  logic        [KW-1:0] leak_shift,
  output logic signed [1:0]    level,
  output logic signed [IW-1:0] qerr,
  output logic                 sat_seen
);
  localparam int WW = IW + 2;
  localparam logic signed [WW-1:0] FS   = WW'(2 ** (DW - 1));
  localparam logic signed [WW-1:0] HALF = WW'(2 ** (DW - 2));
  localparam logic signed [WW-1:0] SMAX = WW'(2 ** (IW - 1) - 1);
  localparam logic signed [WW-1:0] SMIN = -WW'(2 ** (IW - 1));

  logic signed [IW-1:0] acc;
  logic signed [WW-1:0] acc_w, x_w, leaked, fb, sum;
  logic signed [1:0]    q;
  logic                 hi, lo;

  assign acc_w  = {{(WW-IW){acc[IW-1]}}, acc};
  assign x_w    = {{(WW-DW){in_sample[DW-1]}}, in_sample};
  assign leaked = (leak_shift == '0) ? acc_w : acc_w - (acc_w >>> leak_shift);

  always_comb begin
    if (acc_w > HALF)       q = 2'sb01;
    else if (acc_w < -HALF) q = 2'sb11;
    else                    q = 2'sb00;
  end

  assign fb  = (q == 2'sb01) ? FS : (q == 2'sb11) ? -FS : '0;
  assign sum = leaked + x_w - fb;
  assign hi  = sum > SMAX;
  assign lo  = sum < SMIN;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= '0;
      level    <= '0;
      qerr     <= '0;
      sat_seen <= 1'b0;
    end else if (in_valid) begin
      level <= q;
      qerr  <= IW'(fb - acc_w);
      acc   <= hi ? IW'(SMAX) : lo ? IW'(SMIN) : IW'(sum);
      if (hi || lo) sat_seen <= 1'b1;
    end
  end

  p_code_legal_r2: assert property (@(posedge clk) disable iff (rst)
    level != 2'b10);

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(level) && $stable(qerr)));

  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    sat_seen |=> sat_seen);

  p_err_bound_r8: assert property (@(posedge clk) disable iff (rst)
    (level == 2'sb00) |-> ((WW'(qerr) <= HALF) && (WW'(qerr) >= -HALF)));
endmodule

// File: tb/dsm1_modulator_test.sv
module dsm1_modulator_test;
  localparam int DW = 12;
  localparam int IWA = 16;
  localparam int IWB = 12;

  typedef struct {
    int     ya;
    longint ea;
    bit     oa;
    int     yb;
    longint eb;
    bit     ob;
    string  tag;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vld = 1'b0;
  logic signed [DW-1:0] din = '0;
  logic [3:0] kk = '0;
  logic signed [1:0] lvl_a, lvl_b;
  logic signed [IWA-1:0] err_a;
  logic signed [IWB-1:0] err_b;
  logic sat_a, sat_b;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  item_t q[$];
  longint sa = 0, sb = 0;
  bit osa = 0, osb = 0;
  int last_y = 0;
  longint last_e = 0;
  int avg_sum = 0;
  int seed = 12345;

  always #2.5 clk = ~clk;

  dsm1_modulator #(.DW(DW), .GW(4)) uut (
    .clk(clk), .rst(rst), .in_valid(vld), .in_sample(din), .leak_shift(kk),
    .level(lvl_a), .qerr(err_a), .sat_seen(sat_a));

  dsm1_modulator #(.DW(DW), .GW(0)) uut_sat (
    .clk(clk), .rst(rst), .in_valid(vld), .in_sample(din), .leak_shift(kk),
    .level(lvl_b), .qerr(err_b), .sat_seen(sat_b));

  function automatic void model(input longint s, input longint x, input int k, input int iw,
                                output longint sn, output int y, output longint e, output bit sat);
    longint fs, half, l, w, mx, mn;
    fs = 2048; half = 1024;
    y = (s > half) ? 1 : (s < -half) ? -1 : 0;
    e = y * fs - s;
    l = (k == 0) ? s : s - (s >>> k);
    w = l + x - y * fs;
    mx = (64'sd1 <<< (iw - 1)) - 1;
    mn = -(64'sd1 <<< (iw - 1));
    sat = (w > mx) || (w < mn);
    sn = (w > mx) ? mx : (w < mn) ? mn : w;
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input int x, input int k, input string tag);
    item_t it;
    longint sn;
    bit s1;
    @(negedge clk);
    din = DW'(x);
    kk = 4'(k);
    vld = 1'b1;
    model(sa, x, k, IWA, sn, it.ya, it.ea, s1);
    sa = sn; osa = osa | s1;
    it.oa = osa;
    model(sb, x, k, IWB, sn, it.yb, it.eb, s1);
    sb = sn; osb = osb | s1;
    it.ob = osb;
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      vld = 1'b0;
      din = DW'(i * 977 - 1500);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    vld = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    sa = 0; sb = 0; osa = 0; osb = 0;
    last_y = 0; last_e = 0;
    check("R1 level", longint'(lvl_a), 0);
    check("R1 qerr", longint'(err_a), 0);
    check("R1 sat_seen", longint'(sat_a), 0);
    check("R1 sat_seen narrow", longint'(sat_b), 0);
  endtask

  initial begin : monitor
    item_t it;
    bit sv;
    forever begin
      @(posedge clk);
      sv = vld && !rst;
      #1;
      if (sv && q.size() > 0) begin
        it = q.pop_front();
        check({it.tag, " R4 level"}, longint'(lvl_a), it.ya);
        check({it.tag, " R8 qerr"}, longint'(err_a), it.ea);
        check({it.tag, " R7 sat_seen"}, longint'(sat_a), it.oa);
        check({it.tag, " R4 narrow level"}, longint'(lvl_b), it.yb);
        check({it.tag, " R8 narrow qerr"}, longint'(err_b), it.eb);
        check({it.tag, " R7 narrow sat_seen"}, longint'(sat_b), it.ob);
        last_y = it.ya;
        last_e = it.ea;
        if (it.tag == "R9") avg_sum += it.ya;
      end
    end
  end

  initial begin : watchdog
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : driver
    int ly;
    longint le;
    repeat (3) @(negedge clk);
    do_reset();

    // R1 first sample gives 0; R3 ties at +FS/2 and -FS/2
    send(1024, 0, "R1");
    send(0, 0, "R3");
    send(0, 0, "R3");
    send(1, 0, "R3");
    send(0, 0, "R3");
    idle(2);
    check("R3 above threshold gives +1", longint'(lvl_a), 1);
    do_reset();
    send(-1024, 0, "R3");
    send(0, 0, "R3");
    send(-1, 0, "R3");
    send(0, 0, "R3");
    idle(2);
    check("R3 below threshold gives -1", longint'(lvl_a), -1);

    // R5 hold while strobe is low
    ly = last_y; le = last_e;
    idle(5);
    check("R5 level held", longint'(lvl_a), ly);
    check("R5 qerr held", longint'(err_a), le);
    send(0, 0, "R5");
    idle(1);

    // R4 random stream, no leak
    do_reset();
    for (int i = 0; i < 400; i++) begin
      seed = seed * 1103515245 + 12345;
      send((seed >>> 8) % 2048, 0, "R4");
    end
    idle(2);

    // R6 leak, directed then random
    do_reset();
    send(1024, 1, "R6");
    send(0, 1, "R6");
    send(0, 1, "R6");
    idle(2);
    check("R6 leaked error", longint'(err_a), -512);
    for (int k = 1; k < 16; k += 3) begin
      for (int i = 0; i < 60; i++) begin
        seed = seed * 1103515245 + 12345;
        send((seed >>> 8) % 2048, k, "R6");
      end
    end
    idle(2);

    // R7 clamp on narrow instance, positive then negative
    do_reset();
    send(1024, 0, "R7");
    send(2047, 0, "R7");
    send(0, 0, "R7");
    send(0, 0, "R7");
    idle(2);
    check("R7 narrow flag sticky", longint'(sat_b), 1);
    check("R7 wide flag clear", longint'(sat_a), 0);
    do_reset();
    send(-1024, 0, "R7");
    send(-2048, 0, "R7");
    send(0, 0, "R7");
    idle(2);
    check("R7 narrow flag negative", longint'(sat_b), 1);

    // R9 average tracking
    do_reset();
    avg_sum = 0;
    for (int i = 0; i < 32; i++) send(700, 0, "R9");
    idle(2);
    n_chk++;
    if ((avg_sum * 2048 - 32 * 700) > 4096 || (avg_sum * 2048 - 32 * 700) < -4096) begin
      n_fail++;
      $display("FAIL R9 actual=%0d expected=%0d within 2 levels", avg_sum * 2048, 32 * 700);
    end

    idle(3);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule